// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits between a host write stream and an 8-bit parallel flash of 512K locations. The flash has no sectors: erase always clears the whole device. The host first loads a target byte address. It then streams 32-bit words, and each word carries one data byte in its low eight bits. For every word, the sequencer drives the three unlock-and-program command writes and then the data write to the current target. It waits a programmable program time and then moves the target up by one. A long burst therefore programs many consecutive bytes without the host ever issuing a command cycle itself.

A separate request starts the six-write whole-chip erase, followed by a programmable erase wait. Only one operation runs at a time. While an operation runs, a single ready output stays low, so any request held during that time waits and is taken later. When both requests are present in the same idle cycle, priority decides which one is taken first.

Every flash write is a timed bus cycle built from registered strobes. Chip enable and the address and data lines settle one clock before write enable falls. Write enable stays low for a parameterised number of clocks. Chip enable stays low for one more clock after write enable rises.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, fl_we_n and fl_ce_n are 1, busy and done are 0, and cmd_ready is 1.
- R2: For each accepted word, four flash writes occur, in this order as (address, data): (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0), (target, wr_data[7:0]). Bits 31:8 of the word have no effect.
- R3: A pulse on addr_load taken while cmd_ready is 1 sets the target to start_addr. The target then rises by one after every programmed byte, wrapping from 0x7FFFF to 0x00000.
- R4: An accepted erase_req produces six flash writes, in this order: (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x80), (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x10).
- R5: In every flash write, fl_ce_n is low and fl_addr and fl_data are held for one clock before fl_we_n falls. fl_we_n stays low for exactly PULSE_CLKS clocks, and fl_ce_n stays low for one clock after fl_we_n rises. fl_we_n is never low while fl_ce_n is high.
- R6: One byte program keeps busy high for exactly 4*(PULSE_CLKS+3) + cfg_prog_wait + 1 clocks. cmd_ready is low whenever busy is high.
- R7: A chip erase keeps busy high for exactly 6*(PULSE_CLKS+3) + cfg_erase_wait + 1 clocks.
- R8: done is a one-clock pulse in the first idle clock after each completed operation, so there is one pulse per byte and one per erase.
- R9: A request held high while the sequencer is busy is taken once cmd_ready returns, and none is lost. In a single idle clock, erase_req is served first, then addr_load, then wr_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_addr | input | 19 | Target byte address to load |
| addr_load | input | 1 | Load start_addr as the target (taken when cmd_ready) |
| wr_valid | input | 1 | A stream word is present |
| wr_data | input | 32 | Stream word; only bits 7:0 are programmed |
| erase_req | input | 1 | Request a whole-chip erase |
| cmd_ready | output | 1 | High when a request can be taken this clock |
| cfg_prog_wait | input | 16 | Extra clocks waited after each data write |
| cfg_erase_wait | input | 16 | Extra clocks waited after the erase sequence |
| fl_addr | output | 19 | Flash address |
| fl_data | output | 8 | Flash write data |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
The hardest situations to reach are the address wrap in the middle of a burst and two requests colliding in a single idle clock. To reach the wrap, the stimulus loads a target three below the top of the array and streams past it. To reach the collision, the bench raises erase_req together with a stream word, and addr_load together with a word, in the same clock. Each collision must show one order of flash writes, with no request lost. A 256-byte burst with filler in the upper word bits covers every data value. Runs with several wait settings tie the busy length to the timing formulas.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ISSUE,
        SEQ_BUS,
        SEQ_WAIT
    } seq_state_e;

    typedef enum logic {
        OP_PROG,
        OP_ERASE
    } seq_op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } bus_phase_e;

    localparam logic [15:0] UNLOCK_A = 16'h5555;
    localparam logic [15:0] UNLOCK_B = 16'h2AAA;
    localparam logic [7:0]  KEY_A    = 8'hAA;
    localparam logic [7:0]  KEY_B    = 8'h55;
    localparam logic [7:0]  KEY_PROG = 8'hA0;
    localparam logic [7:0]  KEY_ERS  = 8'h80;
    localparam logic [7:0]  KEY_CHIP = 8'h10;

    localparam int PROG_STEPS  = 4;
    localparam int ERASE_STEPS = 6;

endpackage

// File: rtl/flash_step_table.sv
module flash_step_table
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  seq_op_e           op,
    input  logic [2:0]        step,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [DATA_W-1:0] tgt_data,
    output logic [ADDR_W-1:0] step_addr,
    output logic [DATA_W-1:0] step_data,
    output logic              step_last
);

    localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(UNLOCK_A);
    localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(UNLOCK_B);

    always_comb begin
        step_addr = ADR_A;
        step_data = DATA_W'(KEY_A);
        step_last = 1'b0;
        if (op == OP_ERASE) begin
            step_last = (step == 3'(ERASE_STEPS - 1));
            case (step)
                3'd0: begin step_addr = ADR_A; step_data = DATA_W'(KEY_A);    end
                3'd1: begin step_addr = ADR_B; step_data = DATA_W'(KEY_B);    end
                3'd2: begin step_addr = ADR_A; step_data = DATA_W'(KEY_ERS);  end
                3'd3: begin step_addr = ADR_A; step_data = DATA_W'(KEY_A);    end
                3'd4: begin step_addr = ADR_B; step_data = DATA_W'(KEY_B);    end
                default: begin step_addr = ADR_A; step_data = DATA_W'(KEY_CHIP); end
            endcase
        end else begin
            step_last = (step == 3'(PROG_STEPS - 1));
            case (step)
                3'd0: begin step_addr = ADR_A; step_data = DATA_W'(KEY_A);    end
                3'd1: begin step_addr = ADR_B; step_data = DATA_W'(KEY_B);    end
                3'd2: begin step_addr = ADR_A; step_data = DATA_W'(KEY_PROG); end
                default: begin step_addr = tgt_addr; step_data = tgt_data;    end
            endcase
        end
    end

endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int PULSE_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_we_n,
    output logic              bus_ce_n,
    output logic              cycle_end
);

    localparam int CNT_W = (PULSE_CLKS < 2) ? 1 : $clog2(PULSE_CLKS);

    typedef struct packed {
        bus_phase_e        phase;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              we_n;
        logic              ce_n;
    } bus_t;

    bus_t bus_d, bus_q;

    always_comb begin
        bus_d = bus_q;
        case (bus_q.phase)
            PH_IDLE: begin
                if (go) begin
                    bus_d.phase = PH_SETUP;
                    bus_d.addr  = in_addr;
                    bus_d.data  = in_data;
                    bus_d.ce_n  = 1'b0;
                end
            end
            PH_SETUP: begin
                bus_d.phase = PH_STROBE;
                bus_d.we_n  = 1'b0;
                bus_d.cnt   = CNT_W'(PULSE_CLKS - 1);
            end
            PH_STROBE: begin
                if (bus_q.cnt == '0) begin
                    bus_d.phase = PH_HOLD;
                    bus_d.we_n  = 1'b1;
                end else begin
                    bus_d.cnt = bus_q.cnt - 1'b1;
                end
            end
            default: begin
                bus_d.phase = PH_IDLE;
                bus_d.ce_n  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q <= '{phase: PH_IDLE, cnt: '0, addr: '0, data: '0,
                       we_n: 1'b1, ce_n: 1'b1};
        end else begin
            bus_q <= bus_d;
        end
    end

    assign bus_addr  = bus_q.addr;
    assign bus_data  = bus_q.data;
    assign bus_we_n  = bus_q.we_n;
    assign bus_ce_n  = bus_q.ce_n;
    assign cycle_end = (bus_q.phase == PH_HOLD);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int WORD_W     = 32,
    parameter int WAIT_W     = 16,
    parameter int PULSE_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              addr_load,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              erase_req,
    output logic              cmd_ready,
    input  logic [WAIT_W-1:0] cfg_prog_wait,
    input  logic [WAIT_W-1:0] cfg_erase_wait,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_data,
    output logic              fl_we_n,
    output logic              fl_ce_n,
    output logic              busy,
    output logic              done
);

    typedef struct packed {
        seq_state_e        state;
        seq_op_e           op;
        logic [2:0]        step;
        logic [ADDR_W-1:0] tgt_addr;
        logic [DATA_W-1:0] tgt_data;
        logic [WAIT_W-1:0] wait_cnt;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              go;
    logic [ADDR_W-1:0] step_addr;
    logic [DATA_W-1:0] step_data;
    logic              step_last;
    logic              cycle_end;
    logic              unused_hi_bits;

    assign unused_hi_bits = ^wr_data[WORD_W-1:DATA_W];

    flash_step_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_table (
        .op        (seq_q.op),
        .step      (seq_q.step),
        .tgt_addr  (seq_q.tgt_addr),
        .tgt_data  (seq_q.tgt_data),
        .step_addr (step_addr),
        .step_data (step_data),
        .step_last (step_last)
    );

    flash_bus_cycle #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_CLKS(PULSE_CLKS)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .in_addr   (step_addr),
        .in_data   (step_data),
        .bus_addr  (fl_addr),
        .bus_data  (fl_data),
        .bus_we_n  (fl_we_n),
        .bus_ce_n  (fl_ce_n),
        .cycle_end (cycle_end)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        go         = 1'b0;
        case (seq_q.state)
            SEQ_IDLE: begin
                if (erase_req) begin
                    seq_d.op    = OP_ERASE;
                    seq_d.step  = '0;
                    seq_d.state = SEQ_ISSUE;
                end else if (addr_load) begin
                    seq_d.tgt_addr = start_addr;
                end else if (wr_valid) begin
                    seq_d.op       = OP_PROG;
                    seq_d.step     = '0;
                    seq_d.tgt_data = wr_data[DATA_W-1:0];
                    seq_d.state    = SEQ_ISSUE;
                end
            end
            SEQ_ISSUE: begin
                go          = 1'b1;
                seq_d.state = SEQ_BUS;
            end
            SEQ_BUS: begin
                if (cycle_end) begin
                    if (step_last) begin
                        seq_d.state = SEQ_WAIT;
                        if (seq_q.op == OP_ERASE) begin
                            seq_d.wait_cnt = cfg_erase_wait;
                        end else begin
                            seq_d.wait_cnt = cfg_prog_wait;
                            seq_d.tgt_addr = seq_q.tgt_addr + 1'b1;
                        end
                    end else begin
                        seq_d.step  = seq_q.step + 1'b1;
                        seq_d.state = SEQ_ISSUE;
                    end
                end
            end
            default: begin
                if (seq_q.wait_cnt == '0) begin
                    seq_d.state = SEQ_IDLE;
                    seq_d.done  = 1'b1;
                end else begin
                    seq_d.wait_cnt = seq_q.wait_cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SEQ_IDLE, op: OP_PROG, step: '0, tgt_addr: '0,
                       tgt_data: '0, wait_cnt: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cmd_ready = (seq_q.state == SEQ_IDLE);
    assign busy      = (seq_q.state != SEQ_IDLE);
    assign done      = seq_q.done;

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int PULSE_CLKS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [DATA_W-1:0] fl_data,
    input logic              fl_we_n,
    input logic              fl_ce_n,
    input logic              busy,
    input logic              done,
    input logic              cmd_ready
);

    logic [7:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!fl_we_n) begin
            low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    a_r5_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> !fl_ce_n);

    a_r5_setup_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_we_n) |-> ($past(!fl_ce_n) && $stable(fl_addr) && $stable(fl_data)));

    a_r5_stable_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_data)));

    a_r5_hold_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (!fl_ce_n && $stable(fl_addr) && $stable(fl_data)));

    a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we_n && $past(!fl_we_n)) |-> (low_run == 8'(PULSE_CLKS)));

    a_r6_no_ready_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cmd_ready);

    a_r8_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_CLKS(PULSE_CLKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fl_addr   (fl_addr),
    .fl_data   (fl_data),
    .fl_we_n   (fl_we_n),
    .fl_ce_n   (fl_ce_n),
    .busy      (busy),
    .done      (done),
    .cmd_ready (cmd_ready)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int PULSE      = 4;
    localparam int CYC        = PULSE + 3;
    localparam int LOG_MAX    = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] start_addr = '0;
    logic        addr_load = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        erase_req = 1'b0;
    logic        cmd_ready;
    logic [15:0] cfg_prog_wait = '0;
    logic [15:0] cfg_erase_wait = '0;
    logic [18:0] fl_addr;
    logic [7:0]  fl_data;
    logic        fl_we_n;
    logic        fl_ce_n;
    logic        busy;
    logic        done;

    flash_cmd_seq #(.PULSE_CLKS(PULSE)) dut (
        .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .addr_load(addr_load),
        .wr_valid(wr_valid), .wr_data(wr_data), .erase_req(erase_req),
        .cmd_ready(cmd_ready), .cfg_prog_wait(cfg_prog_wait),
        .cfg_erase_wait(cfg_erase_wait), .fl_addr(fl_addr), .fl_data(fl_data),
        .fl_we_n(fl_we_n), .fl_ce_n(fl_ce_n), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int vectors = 0;
    int fails   = 0;

    // bus monitor, sampled away from the active edge
    logic [18:0] log_a [LOG_MAX];
    logic [7:0]  log_d [LOG_MAX];
    int          log_n = 0;
    int          busy_cnt = 0;
    int          done_cnt = 0;
    int          pw_bad = 0;
    int          setup_bad = 0;
    int          run = 0;
    logic        prev_we = 1'b1;
    logic        prev_ce = 1'b1;
    logic [18:0] prev_a = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_we && !fl_we_n) begin
                if (log_n < LOG_MAX) begin
                    log_a[log_n] = fl_addr;
                    log_d[log_n] = fl_data;
                end
                log_n = log_n + 1;
                if (prev_ce || prev_a !== fl_addr) setup_bad = setup_bad + 1;
            end
            if (!prev_we && fl_we_n) begin
                if (run != PULSE || fl_ce_n) pw_bad = pw_bad + 1;
            end
            run = fl_we_n ? 0 : run + 1;
            if (busy) busy_cnt = busy_cnt + 1;
            if (done) done_cnt = done_cnt + 1;
            prev_we = fl_we_n;
            prev_ce = fl_ce_n;
            prev_a  = fl_addr;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors = vectors + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic check_rec(input string req, input int idx, input logic [18:0] a, input logic [7:0] d);
        check(req, {13'd0, log_a[idx]}, {13'd0, a});
        check(req, {24'd0, log_d[idx]}, {24'd0, d});
    endtask

    task automatic check_prog(input string req, input int idx, input logic [18:0] t, input logic [7:0] d);
        check_rec(req, idx,     19'h05555, 8'hAA);
        check_rec(req, idx + 1, 19'h02AAA, 8'h55);
        check_rec(req, idx + 2, 19'h05555, 8'hA0);
        check_rec(req, idx + 3, t, d);
    endtask

    task automatic check_erase(input string req, input int idx);
        check_rec(req, idx,     19'h05555, 8'hAA);
        check_rec(req, idx + 1, 19'h02AAA, 8'h55);
        check_rec(req, idx + 2, 19'h05555, 8'h80);
        check_rec(req, idx + 3, 19'h05555, 8'hAA);
        check_rec(req, idx + 4, 19'h02AAA, 8'h55);
        check_rec(req, idx + 5, 19'h05555, 8'h10);
    endtask

    task automatic load_addr(input logic [18:0] a);
        start_addr = a;
        addr_load  = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        addr_load = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w);
        wr_data  = w;
        wr_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic stream(input logic [18:0] a, input int n, input int pw, input int seed);
        int b0, c0, d0;
        cfg_prog_wait = 16'(pw);
        b0 = busy_cnt; c0 = log_n; d0 = done_cnt;
        load_addr(a);
        for (int i = 0; i < n; i++) begin
            send_word({8'(i * 37 + seed), 8'(~i), 8'(seed), 8'(i * 13 + seed)});
        end
        wait_idle();
        check("R2 write count", 32'(log_n - c0), 32'(4 * n));
        for (int i = 0; i < n; i++) begin
            check_prog("R2/R3 byte program", c0 + 4 * i, 19'((a + 19'(i)) & 19'h7FFFF), 8'(i * 13 + seed));
        end
        check("R6 busy clocks", 32'(busy_cnt - b0), 32'(n * (4 * CYC + pw + 1)));
        check("R8 done pulses", 32'(done_cnt - d0), 32'(n));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails = fails + 1;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int b0, c0, d0;
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 we_n", {31'd0, fl_we_n}, 32'd1);
        check("R1 ce_n", {31'd0, fl_ce_n}, 32'd1);
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 ready", {31'd0, cmd_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 wrap at the top, several program waits
        stream(19'h7FFFD, 6, 0, 5);
        stream(19'h7FFFE, 3, 1, 90);
        stream(19'h01234, 4, 7, 200);
        // R2 full data sweep with filler in bits 31:8
        stream(19'h00100, 256, 1, 0);

        // R4/R7 erase with several waits
        for (int k = 0; k < 3; k++) begin
            cfg_erase_wait = 16'(k * 3);
            b0 = busy_cnt; c0 = log_n; d0 = done_cnt;
            erase_req = 1'b1;
            while (!cmd_ready) @(negedge clk);
            @(negedge clk);
            erase_req = 1'b0;
            wait_idle();
            check("R4 write count", 32'(log_n - c0), 32'd6);
            check_erase("R4 erase sequence", c0);
            check("R7 busy clocks", 32'(busy_cnt - b0), 32'(6 * CYC + k * 3 + 1));
            check("R8 done pulses", 32'(done_cnt - d0), 32'd1);
        end

        // R9 erase and write in the same idle clock: erase first, write kept
        cfg_prog_wait = 16'd2;
        cfg_erase_wait = 16'd1;
        load_addr(19'h00777);
        c0 = log_n; d0 = done_cnt;
        erase_req = 1'b1;
        wr_data   = 32'hDEAD_BE3C;
        wr_valid  = 1'b1;
        @(negedge clk);
        erase_req = 1'b0;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        wait_idle();
        check("R9 writes after collision", 32'(log_n - c0), 32'd10);
        check_erase("R9 erase served first", c0);
        check_prog("R9 held write kept", c0 + 6, 19'h00777, 8'h3C);
        check("R9 done pulses", 32'(done_cnt - d0), 32'd2);

        // R9 address load and write together: load first, write at new target
        c0 = log_n;
        start_addr = 19'h4ABCD;
        addr_load  = 1'b1;
        wr_data    = 32'h1111_1166;
        wr_valid   = 1'b1;
        @(negedge clk);
        addr_load = 1'b0;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        wait_idle();
        check("R9 load before write count", 32'(log_n - c0), 32'd4);
        check_prog("R9 load before write", c0, 19'h4ABCD, 8'h66);

        // R5 strobe shape over every write seen
        check("R5 pulse width or hold", 32'(pw_bad), 32'd0);
        check("R5 setup before strobe", 32'(setup_bad), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule